// File: doc/BRIEF.md
# Disk DMA Request Controller

This block produces the DMA request line that a disk interface controller presents to the system DMA engine, clocked by the bus clock. It handles four transfer kinds: multi-word write, multi-word read, Ultra DMA write and Ultra DMA read. Each kind uses its own rule for when the request falls. In the multi-word kinds the request falls right after any bus access to the FIFO. In Ultra write it follows the write FIFO fill level. In Ultra read a counter of bus reads drops the request after a full burst, or earlier when the read FIFO runs dry.

The FIFOs, the device-side strobe timing, the bus decoder and the DMA engine are outside the block. They appear only as strobes, levels and flags at the ports. The request output is registered, so every drop and rise shows up exactly one bus clock after the cycle whose inputs caused it. The transfer kind is encoded as {`ultra_i`, `dir_rd_i`}: 00 is multi-word write, 01 is multi-word read, 10 is Ultra write and 11 is Ultra read.

Top module: `dmareq_ctrl`

## Requirements
- R1: After reset, and one cycle after any cycle with `en_i` low, `dreq_o` is 0 and `qcnt_o` is 0.
- R2: In multi-word write (kind 00), a cycle with `bus_wr_i` high makes `dreq_o` 0 in the next cycle.
- R3: In multi-word read (kind 01), a cycle with `bus_rd_i` high makes `dreq_o` 0 in the next cycle.
- R4: In the multi-word kinds, a cycle with no access drives `dreq_o` to 1 in the next cycle only if `dev_req_i` is 1 and the FIFO can proceed. For write this means `wr_lvl_i` < DEPTH; for read it means `rd_lvl_i` != 0. Otherwise the next value is 0.
- R5: In Ultra write (kind 10), `dreq_o` in the next cycle is 1 when `wr_lvl_i` < BURST (default 4) and 0 when `wr_lvl_i` >= BURST.
- R6: In Ultra read (kind 11), each `bus_rd_i` while `dreq_o` is 1 raises `qcnt_o` by one. The read that brings it to BURST drops `dreq_o` in the next cycle, and `qcnt_o` then shows BURST.
- R7: In Ultra read, `rd_empty_i` high while `dreq_o` is 1 drops `dreq_o` in the next cycle and leaves `qcnt_o` unchanged.
- R8: In Ultra read, while `dreq_o` is 0, reads are ignored and `qcnt_o` holds. The request rises in the next cycle when `rd_lvl_i` >= BURST, or when `dev_req_i` is 0 and `rd_lvl_i` != 0 (the tail of the transfer). A rise clears `qcnt_o` to 0.
- R9: While enabled, a cycle in which the kind differs from the kind in the previous cycle makes `dreq_o` 0 and `qcnt_o` 0 in the next cycle. The new kind's rules apply from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable |
| ultra_i | input | 1 | 1 = Ultra DMA, 0 = multi-word DMA |
| dir_rd_i | input | 1 | 1 = bus reads the read FIFO, 0 = bus writes the write FIFO |
| bus_wr_i | input | 1 | Bus write strobe into the write FIFO |
| bus_rd_i | input | 1 | Bus read strobe from the read FIFO |
| wr_lvl_i | input | LVL_W | Write FIFO occupancy |
| rd_lvl_i | input | LVL_W | Read FIFO occupancy |
| rd_empty_i | input | 1 | Read FIFO empty flag |
| dev_req_i | input | 1 | Device-side transfer request |
| dreq_o | output | 1 | DMA request to the DMA engine |
| qcnt_o | output | CNT_W | Ultra read burst counter |

## Verification
The bench targets several edge cases:
- The exact cycle of each drop. A design that let one extra access through would leave the request high for an extra cycle.
- The fourth read of an Ultra burst. A counter off by one would drop after three reads or after five.
- The early drop on an empty FIFO, which must not disturb the count.
- Reads that arrive while the request is low. A design that counted them would show a wrong count and could drop at the wrong point in the next burst.
- Fill levels right at BURST and at DEPTH.
- The forced low cycle on a kind change. A design that skipped it would carry the old request straight into the new kind.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    // Transfer kind, encoded as {ultra, dir_rd}
    typedef enum logic [1:0] {
        XF_MW_WR = 2'b00,
        XF_MW_RD = 2'b01,
        XF_UL_WR = 2'b10,
        XF_UL_RD = 2'b11
    } xfer_e;

    typedef struct packed {
        xfer_e kind;
    } mode_st_t;

    typedef struct packed {
        logic dreq;
    } req_st_t;

endpackage

// File: rtl/dmareq_mode.sv
module dmareq_mode
    import dmareq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ultra_i,
    input  logic  dir_rd_i,
    output xfer_e kind_o,
    output logic  chg_o
);

    mode_st_t st_d, st_q;
    xfer_e    kind_now;

    always_comb begin
        kind_now  = xfer_e'({ultra_i, dir_rd_i});
        st_d      = st_q;
        st_d.kind = kind_now;
        chg_o     = (kind_now != st_q.kind);
        kind_o    = kind_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{kind: XF_MW_WR};
        else        st_q <= st_d;
    end

    // R9
    kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_o |=> (st_q.kind == $past(kind_now)));

endmodule

// File: rtl/dmareq_qcnt.sv
module dmareq_qcnt #(
    parameter int BURST = 4,
    localparam int CNT_W = $clog2(BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                            cnt_d = '0;
        else if (inc_i && cnt_q < CNT_W'(BURST)) cnt_d = cnt_q + 1'b1;
        cnt_o  = cnt_q;
        last_o = (cnt_q == CNT_W'(BURST - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && cnt_q < CNT_W'(BURST)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BURST));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dmareq_ctrl.sv
module dmareq_ctrl
    import dmareq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 4,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ultra_i,
    input  logic             dir_rd_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [LVL_W-1:0] wr_lvl_i,
    input  logic [LVL_W-1:0] rd_lvl_i,
    input  logic             rd_empty_i,
    input  logic             dev_req_i,
    output logic             dreq_o,
    output logic [CNT_W-1:0] qcnt_o
);

    xfer_e   kind;
    logic    chg;
    logic    cnt_clr, cnt_inc, cnt_last;
    req_st_t st_d, st_q;

    dmareq_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ultra_i  (ultra_i),
        .dir_rd_i (dir_rd_i),
        .kind_o   (kind),
        .chg_o    (chg)
    );

    dmareq_qcnt #(.BURST(BURST)) u_qcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (qcnt_o),
        .last_o (cnt_last)
    );

    logic wr_room, rd_data, wr_high, rd_high, rd_tail;

    always_comb begin
        wr_room = (wr_lvl_i < LVL_W'(DEPTH));
        rd_data = (rd_lvl_i != '0);
        wr_high = (wr_lvl_i >= LVL_W'(BURST));
        rd_high = (rd_lvl_i >= LVL_W'(BURST));
        rd_tail = !dev_req_i && rd_data;

        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;

        if (!en_i || chg) begin
            st_d.dreq = 1'b0;
            cnt_clr   = 1'b1;
        end else begin
            unique case (kind)
                XF_MW_WR: begin
                    cnt_clr   = 1'b1;
                    st_d.dreq = !bus_wr_i && dev_req_i && wr_room;
                end
                XF_MW_RD: begin
                    cnt_clr   = 1'b1;
                    st_d.dreq = !bus_rd_i && dev_req_i && rd_data;
                end
                XF_UL_WR: begin
                    cnt_clr   = 1'b1;
                    st_d.dreq = !wr_high;
                end
                XF_UL_RD: begin
                    if (st_q.dreq) begin
                        cnt_inc = bus_rd_i;
                        if ((bus_rd_i && cnt_last) || rd_empty_i)
                            st_d.dreq = 1'b0;
                    end else if (rd_high || rd_tail) begin
                        st_d.dreq = 1'b1;
                        cnt_clr   = 1'b1;
                    end
                end
                default: st_d.dreq = 1'b0;
            endcase
        end
        dreq_o = st_q.dreq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{dreq: 1'b0};
        else        st_q <= st_d;
    end

    // R1
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!dreq_o && qcnt_o == '0));

    // R2
    mw_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ultra_i && !dir_rd_i && bus_wr_i) |=> !dreq_o);

    // R3
    mw_rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ultra_i && dir_rd_i && bus_rd_i) |=> !dreq_o);

    // R5
    ul_wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ultra_i && !dir_rd_i && wr_high) |=> !dreq_o);

    // R7
    ul_rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !chg && kind == XF_UL_RD && dreq_o && rd_empty_i) |=> !dreq_o);

    // R8
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq_o) |-> (qcnt_o == '0));

    // R9
    swap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && chg) |=> (!dreq_o && qcnt_o == '0));

endmodule

// File: tb/dmareq_ctrl_tb.sv
module dmareq_ctrl_tb;

    localparam int DEPTH = 16;
    localparam int BURST = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int CNT_W = $clog2(BURST + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0, ultra_i = 1'b0, dir_rd_i = 1'b0;
    logic             bus_wr_i = 1'b0, bus_rd_i = 1'b0;
    logic [LVL_W-1:0] wr_lvl_i = '0, rd_lvl_i = '0;
    logic             rd_empty_i = 1'b0, dev_req_i = 1'b0;
    logic             dreq_o;
    logic [CNT_W-1:0] qcnt_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dmareq_ctrl #(.DEPTH(DEPTH), .BURST(BURST)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .ultra_i(ultra_i),
        .dir_rd_i(dir_rd_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
        .wr_lvl_i(wr_lvl_i), .rd_lvl_i(rd_lvl_i), .rd_empty_i(rd_empty_i),
        .dev_req_i(dev_req_i), .dreq_o(dreq_o), .qcnt_o(qcnt_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_both(string req, int exp_req, int exp_cnt);
        chk(req, "dreq", int'(dreq_o), exp_req);
        chk(req, "qcnt", int'(qcnt_o), exp_cnt);
    endtask

    task automatic t_reset();
        chk_both("R1", 0, 0);
    endtask

    task automatic t_mw_write();
        en_i = 1; ultra_i = 0; dir_rd_i = 0; dev_req_i = 1; wr_lvl_i = 0;
        step(); chk_both("R4", 1, 0);
        bus_wr_i = 1;
        step(); chk_both("R2", 0, 0);
        bus_wr_i = 0;
        step(); chk_both("R4", 1, 0);
        wr_lvl_i = LVL_W'(DEPTH);
        step(); chk_both("R4", 0, 0);
        wr_lvl_i = 3; dev_req_i = 0;
        step(); chk_both("R4", 0, 0);
        dev_req_i = 1;
        step(); chk_both("R4", 1, 0);
    endtask

    task automatic t_mw_read();
        dir_rd_i = 1; rd_lvl_i = 5; dev_req_i = 1;
        step(); chk_both("R9", 0, 0);
        step(); chk_both("R4", 1, 0);
        bus_rd_i = 1;
        step(); chk_both("R3", 0, 0);
        bus_rd_i = 0;
        step(); chk_both("R4", 1, 0);
        rd_lvl_i = 0;
        step(); chk_both("R4", 0, 0);
    endtask

    task automatic t_ul_write();
        ultra_i = 1; dir_rd_i = 0; wr_lvl_i = 1;
        step(); chk_both("R9", 0, 0);
        step(); chk_both("R5", 1, 0);
        wr_lvl_i = LVL_W'(BURST);
        step(); chk_both("R5", 0, 0);
        wr_lvl_i = 7;
        step(); chk_both("R5", 0, 0);
        wr_lvl_i = LVL_W'(BURST - 1);
        step(); chk_both("R5", 1, 0);
    endtask

    task automatic t_ul_read();
        ultra_i = 1; dir_rd_i = 1; rd_lvl_i = 8; dev_req_i = 1;
        step(); chk_both("R9", 0, 0);
        step(); chk_both("R8", 1, 0);
        bus_rd_i = 1;
        for (int i = 1; i < BURST; i++) begin
            step(); chk_both("R6", 1, i);
        end
        step(); chk_both("R6", 0, BURST);
        rd_lvl_i = 2;
        step(); chk_both("R8", 0, BURST);
        bus_rd_i = 0; dev_req_i = 0;
        step(); chk_both("R8", 1, 0);
        bus_rd_i = 1;
        step(); chk_both("R6", 1, 1);
        bus_rd_i = 0; rd_empty_i = 1;
        step(); chk_both("R7", 0, 1);
        rd_empty_i = 0; rd_lvl_i = 0; dev_req_i = 1;
        step(); chk_both("R8", 0, 1);
        rd_lvl_i = LVL_W'(BURST);
        step(); chk_both("R8", 1, 0);
    endtask

    task automatic t_disable();
        bus_rd_i = 1;
        step(); chk_both("R6", 1, 1);
        en_i = 0; bus_rd_i = 0;
        step(); chk_both("R1", 0, 0);
        step(); chk_both("R1", 0, 0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mw_write();
        t_mw_read();
        t_ul_write();
        t_ul_read();
        t_disable();
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule